// File: doc/BRIEF.md
# Serial-Fed Eight-Channel Output Driver Controller

This block is the field-side logic of an eight-channel low-side digital output card. A host sends a 24-bit frame over a slow, fully static serial link made of a shift clock, a data line and an active-low chip-select that also acts as the latch strobe. The frame carries one command bit per output and two status-LED bits per output: a red one and an orange one. The frame is held in a shift register and reaches the outputs only when the latch line rises. A data-out pin carries the bit that leaves the far end of the shift register, so several cards can be chained on one link.

The power stage reports faults as digital flags. An overcurrent flag on a channel that is switched on turns that channel off for a fixed retry time, counted in system clocks. After that time the channel is switched on again. An over-temperature flag forces every output off for as long as it is raised. The outputs form two groups of four. Each group produces its own fault term, and the two terms are merged onto one active-low fault pin. An active-high card reset clears the frame, the outputs and any pending fault.

Top module: `dout_card_ctrl`

## Requirements
- R1: A frame is 24 bits, shifted most significant bit first. After latching, bit 16+k of the frame drives `out_en[k]` for k = 0..7, so bit 23 drives channel 7.
- R2: Bits 15..0 drive the LEDs. Bit 2k+1 drives `led_red[k]` and bit 2k drives `led_org[k]`, so the last bit shifted in is the orange LED of channel 0.
- R3: Each rising edge of `ser_clk`, after two-flop synchronisation, shifts in the value present on `ser_din`. `ser_dout` always shows the bit that was shifted in 24 edges earlier, which is the top bit of the shift register.
- R4: The outputs and LEDs take the shifted data only on a rising edge of `latch_n`. Shifting while `latch_n` is low leaves them unchanged.
- R5: An overcurrent flag on a channel that is commanded on switches off only that channel and drives `fault_n` low.
- R6: After RETRY_CYCLES system clocks, a tripped channel switches back on and its fault is released. If its flag is still raised at that moment, the channel stays off and the timer starts again.
- R7: While `hot_flag` is high, all outputs are off and `fault_n` is low. When the flag clears, the outputs return to their latched commands.
- R8: `card_rst` high clears the shift register, the output and LED registers and all tripped channels. `fault_n` is then released unless `hot_flag` is high.
- R9: Channels 0-3 and channels 4-7 each produce a group fault term. `fault_n` is low when either group term is active.
- R10: The link is static. A shift clock held at each level for hundreds of system clocks still transfers every bit correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| card_rst | input | 1 | Active-high card reset from the host, synchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data in |
| latch_n | input | 1 | Active-low chip-select; its rising edge latches the frame |
| ser_dout | output | 1 | Serial data out, for chaining further cards |
| ovc_flag | input | 8 | Per-channel overcurrent flags |
| hot_flag | input | 1 | Over-temperature flag |
| out_en | output | 8 | Output switch enables, channel k on bit k |
| led_red | output | 8 | Red status LED enables |
| led_org | output | 8 | Orange status LED enables |
| fault_n | output | 1 | Active-low global fault |

## Verification
The bench builds the block with RETRY_CYCLES set to 20 instead of the default of tens of thousands. This lets it watch a complete trip-wait-retry cycle, and also a restarted retry, in well under a hundred clocks, and the channel count and group size stay at their defaults. The shift clock is held for several system clocks per phase, and for hundreds of clocks in the static test. This places every edge well clear of the synchroniser, so the expected frame can be computed exactly from the bits that were sent.

// File: rtl/dout_card_pkg.sv
package dout_card_pkg;
  typedef enum logic {
    GUARD_RUN  = 1'b0,
    GUARD_WAIT = 1'b1
  } guard_state_e;
endpackage

// File: rtl/dcc_serial_front.sv
module dcc_serial_front #(
  parameter int FRAME_W     = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               ser_clk,
  input  logic               ser_din,
  input  logic               latch_n,
  output logic [FRAME_W-1:0] frame,
  output logic               ser_dout
);
  logic [SYNC_STAGES-1:0] sck_sync, din_sync, lat_sync;
  logic                   sck_last, lat_last;
  logic                   sck_rise, lat_rise;
  logic [FRAME_W-1:0]     shift_q, shift_d;
  logic [FRAME_W-1:0]     frame_q, frame_d;

  // synchronisers and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync <= '0;
      din_sync <= '0;
      lat_sync <= '1;
      sck_last <= 1'b0;
      lat_last <= 1'b1;
    end else begin
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], ser_clk};
      din_sync <= {din_sync[SYNC_STAGES-2:0], ser_din};
      lat_sync <= {lat_sync[SYNC_STAGES-2:0], latch_n};
      sck_last <= sck_sync[SYNC_STAGES-1];
      lat_last <= lat_sync[SYNC_STAGES-1];
    end
  end

  assign sck_rise = sck_sync[SYNC_STAGES-1] & ~sck_last;
  assign lat_rise = lat_sync[SYNC_STAGES-1] & ~lat_last;

  always_comb begin
    shift_d = shift_q;
    frame_d = frame_q;
    if (clr) begin
      shift_d = '0;
      frame_d = '0;
    end else begin
      if (sck_rise) shift_d = {shift_q[FRAME_W-2:0], din_sync[SYNC_STAGES-1]};
      if (lat_rise) frame_d = shift_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      frame_q <= '0;
    end else begin
      shift_q <= shift_d;
      frame_q <= frame_d;
    end
  end

  assign frame    = frame_q;
  assign ser_dout = shift_q[FRAME_W-1];

  // R4: outputs change only on a latch edge or a clear
  assert_hold_between_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_rise && !clr) |=> $stable(frame_q));

  // R3: a shift edge moves the old top-1 bit to the data-out position
  assert_shift_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && !clr) |=> (ser_dout == $past(shift_q[FRAME_W-2])));
endmodule

// File: rtl/dcc_chan_guard.sv
module dcc_chan_guard
  import dout_card_pkg::*;
#(
  parameter int RETRY_CYCLES = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cmd_on,
  input  logic ovc,
  output logic tripped
);
  localparam int CNT_W = $clog2(RETRY_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RETRY_CYCLES - 1);

  guard_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (clr) begin
      state_d = GUARD_RUN;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      case (state_q)
        GUARD_RUN: if (cmd_on && ovc) begin
          state_d = GUARD_WAIT;
          cnt_d   = RELOAD;
          cnt_en  = 1'b1;
        end
        GUARD_WAIT: begin
          cnt_en = 1'b1;
          if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
          end else if (ovc) begin
            cnt_d = RELOAD;
          end else begin
            state_d = GUARD_RUN;
          end
        end
        default: state_d = GUARD_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GUARD_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign tripped = (state_q == GUARD_WAIT);

  // R5: an overcurrent on an enabled, running channel trips it
  assert_trip_on_ovc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tripped && cmd_on && ovc && !clr) |=> tripped);

  // R6: expiry with the flag gone releases the channel
  assert_retry_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && cnt_q == '0 && !ovc && !clr) |=> !tripped);

  // R6: expiry with the flag still present keeps it tripped
  assert_retry_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && ovc && !clr) |=> tripped);
endmodule

// File: rtl/dout_card_ctrl.sv
module dout_card_ctrl #(
  parameter int NUM_CH       = 8,
  parameter int GROUP_CH     = 4,
  parameter int RETRY_CYCLES = 60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_rst,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              latch_n,
  output logic              ser_dout,
  input  logic [NUM_CH-1:0] ovc_flag,
  input  logic              hot_flag,
  output logic [NUM_CH-1:0] out_en,
  output logic [NUM_CH-1:0] led_red,
  output logic [NUM_CH-1:0] led_org,
  output logic              fault_n
);
  localparam int FRAME_W    = 3 * NUM_CH;
  localparam int NUM_GROUPS = NUM_CH / GROUP_CH;

  logic [FRAME_W-1:0]    frame;
  logic [NUM_CH-1:0]     cmd, tripped;
  logic [NUM_GROUPS-1:0] grp_fault;

  dcc_serial_front #(.FRAME_W(FRAME_W), .SYNC_STAGES(2)) u_front (
    .clk(clk), .rst_n(rst_n), .clr(card_rst),
    .ser_clk(ser_clk), .ser_din(ser_din), .latch_n(latch_n),
    .frame(frame), .ser_dout(ser_dout)
  );

  assign cmd = frame[FRAME_W-1 -: NUM_CH];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    dcc_chan_guard #(.RETRY_CYCLES(RETRY_CYCLES)) u_guard (
      .clk(clk), .rst_n(rst_n), .clr(card_rst),
      .cmd_on(cmd[k]), .ovc(ovc_flag[k]), .tripped(tripped[k])
    );
    assign led_red[k] = frame[2*k+1];
    assign led_org[k] = frame[2*k];
    assign out_en[k]  = cmd[k] & ~tripped[k] & ~hot_flag;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_fault[g] = (|tripped[g*GROUP_CH +: GROUP_CH]) | hot_flag;
  end

  assign fault_n = ~(|grp_fault);

  // R7: over-temperature forces every output off and flags a fault
  assert_hot_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hot_flag |-> (out_en == '0 && !fault_n));

  // R8: a card reset leaves outputs and LEDs cleared
  assert_card_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> (out_en == '0 && led_red == '0 && led_org == '0));

  // R9: fault line is released only when no channel is tripped
  assert_fault_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_n |-> (tripped == '0));
endmodule

// File: tb/dout_card_ctrl_bench.sv
module dout_card_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RETRY      = 20;

  logic       clk = 1'b0;
  logic       rst_n, card_rst, ser_clk, ser_din, latch_n, hot_flag;
  logic [7:0] ovc_flag;
  logic       ser_dout, fault_n;
  logic [7:0] out_en, led_red, led_org;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dout_card_ctrl #(.NUM_CH(8), .GROUP_CH(4), .RETRY_CYCLES(RETRY)) u_dout_card_ctrl (
    .clk(clk), .rst_n(rst_n), .card_rst(card_rst),
    .ser_clk(ser_clk), .ser_din(ser_din), .latch_n(latch_n),
    .ser_dout(ser_dout), .ovc_flag(ovc_flag), .hot_flag(hot_flag),
    .out_en(out_en), .led_red(led_red), .led_org(led_org), .fault_n(fault_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] mk_frame(input logic [7:0] o, input logic [7:0] r, input logic [7:0] g);
    logic [23:0] f;
    f[23:16] = o;
    for (int k = 0; k < 8; k++) begin
      f[2*k+1] = r[k];
      f[2*k]   = g[k];
    end
    return f;
  endfunction

  task automatic send_bit(input logic b, input int hold);
    ser_din = b;
    ser_clk = 1'b0;
    tick(hold);
    ser_clk = 1'b1;
    tick(hold);
  endtask

  task automatic shift_frame(input logic [23:0] f, input int hold);
    latch_n = 1'b0;
    tick(2);
    for (int i = 23; i >= 0; i--) send_bit(f[i], hold);
  endtask

  task automatic do_latch();
    latch_n = 1'b1;
    tick(6);
  endtask

  task automatic test_reset_state();
    check("R8 reset out_en", out_en, 0);
    check("R8 reset leds", {led_red, led_org}, 0);
    check("R8 reset fault_n", fault_n, 1);
  endtask

  task automatic test_frame_map();
    logic [23:0] f;
    f = mk_frame(8'hA5, 8'h3C, 8'hC1);
    shift_frame(f, 4);
    check("R1 ser_dout top bit", ser_dout, f[23]);
    do_latch();
    check("R1 outputs", out_en, 8'hA5);
    check("R2 red leds", led_red, 8'h3C);
    check("R2 orange leds", led_org, 8'hC1);
    f = mk_frame(8'h01, 8'h80, 8'h01);
    shift_frame(f, 4);
    do_latch();
    check("R1 ch0 only", out_en, 8'h01);
    check("R2 red7 orange0", {led_red, led_org}, 16'h8001);
  endtask

  task automatic test_hold_and_chain();
    logic [23:0] f;
    f = mk_frame(8'h5A, 8'h0F, 8'hF0);
    shift_frame(f, 4);
    check("R4 hold during shift", out_en, 8'h01);
    check("R3 dout after 24", ser_dout, f[23]);
    send_bit(1'b0, 4);
    check("R3 dout after 25", ser_dout, f[22]);
    check("R4 still held", {led_red, led_org}, 16'h8001);
    do_latch();
    check("R3 latched shifted-by-one", out_en, f[22:15]);
  endtask

  task automatic test_static_clock();
    logic [23:0] f;
    f = mk_frame(8'hFF, 8'h00, 8'hFF);
    shift_frame(f, 300);
    do_latch();
    check("R10 slow clock outputs", out_en, 8'hFF);
    check("R10 slow clock leds", {led_red, led_org}, 16'h00FF);
  endtask

  task automatic test_overcurrent();
    ovc_flag = 8'h08;
    tick(2);
    check("R5 tripped ch3 off", out_en, 8'hF7);
    check("R5 fault low", fault_n, 0);
    ovc_flag = 8'h00;
    tick(8);
    check("R6 still waiting", out_en, 8'hF7);
    tick(20);
    check("R6 retried on", out_en, 8'hFF);
    check("R6 fault released", fault_n, 1);
    ovc_flag = 8'h20;
    tick(45);
    check("R6 restart keeps off", out_en, 8'hDF);
    check("R9 group1 fault", fault_n, 0);
    ovc_flag = 8'h00;
    tick(45);
    check("R6 recover after restart", out_en, 8'hFF);
    check("R9 fault clear", fault_n, 1);
  endtask

  task automatic test_hot();
    hot_flag = 1'b1;
    tick(2);
    check("R7 hot all off", out_en, 0);
    check("R7 hot fault", fault_n, 0);
    hot_flag = 1'b0;
    tick(2);
    check("R7 resume", out_en, 8'hFF);
    check("R7 fault clear", fault_n, 1);
  endtask

  task automatic test_card_reset();
    ovc_flag = 8'h04;
    tick(2);
    check("R5 ch2 trip before reset", fault_n, 0);
    ovc_flag = 8'h00;
    card_rst = 1'b1;
    tick(1);
    card_rst = 1'b0;
    tick(2);
    check("R8 outputs cleared", out_en, 0);
    check("R8 leds cleared", {led_red, led_org}, 0);
    check("R8 fault cleared", fault_n, 1);
    check("R8 chain cleared", ser_dout, 0);
    latch_n = 1'b0;
    tick(4);
    do_latch();
    check("R8 shift reg cleared", out_en, 0);
  endtask

  initial begin
    rst_n = 1'b0; card_rst = 1'b0; ser_clk = 1'b0; ser_din = 1'b0;
    latch_n = 1'b1; hot_flag = 1'b0; ovc_flag = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    test_reset_state();
    test_frame_map();
    test_hold_and_chain();
    test_static_clock();
    test_overcurrent();
    test_hot();
    test_card_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule